// File: doc/BRIEF.md
# Tap-Select Dual-Clock I/Q Sample FIFO

This block is the last stage of a quadrature down-converter chain. Four candidate I/Q streams arrive in the sample clock domain: the raw channel-matched samples, the mixer output, and the outputs of the first and second decimators. A two-bit select picks one of them. The chosen stream is registered and written into a dual-clock FIFO as one 32-bit word per sample, with the signed I value in the upper half and the signed Q value in the lower half. The two undecimated taps produce a word on every sample clock. The two decimated taps write only when their decimator flags a valid output.

The control side reads the FIFO one 16-bit half at a time on its own clock. A register-read path raises a read enable, and for each stored sample the I half comes out first and the Q half second. The second read retires the sample. The read side also provides an empty indication and a level flag. The level flag rises once the FIFO holds at least a programmable number of samples, 2048 by default, so software knows a burst can be drained safely.

The write and read pointers cross between the clock domains as Gray codes through two-flop synchronisers. A flush request on the control side runs a request/acknowledge handshake into the sample domain. The handshake clears both pointers and the overflow record. While the FIFO is full, incoming samples are discarded and a sticky overflow flag is set.

Top module: `iqf_sample_fifo`

## Requirements
- R1: Each stored sample is one 32-bit word: I in bits [31:16], Q in bits [15:0], taken unchanged from the selected tap input.
- R2: `tap_sel` encoding: 0 = raw, 1 = mixed, 2 = first decimator, 3 = second decimator; only the selected tap's word is stored.
- R3: With `tap_sel` 0 or 1, one word is written for every sample clock cycle.
- R4: With `tap_sel` 2 or 3, a word is written only in cycles where that tap's valid input (`dec1_vld` or `dec2_vld`) is high.
- R5: Each read enable accepted while not empty returns one 16-bit half on `rd_data` one control clock later. The first read of a sample returns I, the second returns Q, and only the second read consumes the sample.
- R6: A read enable while `empty` is high has no effect: `rd_data` holds its value and no sample is consumed.
- R7: `thresh_flag` is high when the number of samples not yet fully read is at least THRESH (default 2048), and low otherwise.
- R8: The FIFO holds 2^AW samples (default 4096). A write arriving while the FIFO is full is dropped, and the samples already stored are kept in order.
- R9: `ovf_flag` is set by any dropped write and stays set until a flush or a sample-domain reset.
- R10: A one-cycle `flush` pulse discards all stored samples and clears `ovf_flag`. `empty` reads high until the flush has completed, and `rd_data` keeps its last value.
- R11: After reset, `empty` is 1 and `thresh_flag`, `ovf_flag` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp_clk | input | 1 | Sample-domain clock |
| smp_rst | input | 1 | Synchronous active-high reset, sample domain |
| tap_sel | input | 2 | Tap choice: 0 raw, 1 mixed, 2 decimator 1, 3 decimator 2 |
| tap_raw | input | 32 | Raw I/Q word (I high, Q low) |
| tap_mix | input | 32 | Mixer output I/Q word |
| tap_dec1 | input | 32 | First decimator I/Q word |
| dec1_vld | input | 1 | First decimator output valid |
| tap_dec2 | input | 32 | Second decimator I/Q word |
| dec2_vld | input | 1 | Second decimator output valid |
| ovf_flag | output | 1 | Sticky dropped-sample flag (sample domain) |
| ctl_clk | input | 1 | Control-domain clock |
| ctl_rst | input | 1 | Synchronous active-high reset, control domain |
| flush | input | 1 | One-cycle request to empty the FIFO |
| rd_en | input | 1 | Read one 16-bit half |
| rd_data | output | 16 | Read data, I half then Q half |
| empty | output | 1 | No sample available to read |
| thresh_flag | output | 1 | At least THRESH samples available |

## Verification
A tap word driven before a sample clock edge is registered at that edge and written at the next one. The bench therefore stops all writes and lets the pointers resynchronise for twenty control cycles before it reads anything back. Read data is due one control clock after the edge that samples `rd_en`, so the bench raises `rd_en` on one falling edge and reads `rd_data` on the next. The level and empty flags trail a write by one sample cycle plus three control cycles, so the bench samples them at least twelve control cycles after the last write. A flush completes its round trip in under twenty control cycles, and the bench waits forty before checking the cleared state. The overflow flag is sampled after the fill has ended.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  // Width of one signed I or Q value.
  parameter int unsigned SMP_W = 16;

  typedef enum logic [1:0] {
    TAP_RAW  = 2'd0,
    TAP_MIX  = 2'd1,
    TAP_DEC1 = 2'd2,
    TAP_DEC2 = 2'd3
  } tap_e;
endpackage

// File: rtl/iqf_sync.sv
module iqf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/iqf_tap_mux.sv
module iqf_tap_mux
  import iqf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] mix_i,
  input  logic [DW-1:0] dec1_i,
  input  logic          dec1_vld_i,
  input  logic [DW-1:0] dec2_i,
  input  logic          dec2_vld_i,
  output logic [DW-1:0] word_o,
  output logic          vld_o
);
  tap_e sel_e;
  assign sel_e = tap_e'(sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      unique case (sel_e)
        TAP_RAW:  begin word_o <= raw_i;  vld_o <= 1'b1;       end
        TAP_MIX:  begin word_o <= mix_i;  vld_o <= 1'b1;       end
        TAP_DEC1: begin word_o <= dec1_i; vld_o <= dec1_vld_i; end
        TAP_DEC2: begin word_o <= dec2_i; vld_o <= dec2_vld_i; end
      endcase
    end
  end

  // R3: undecimated taps present a write every cycle
  p_nondec_write_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_e == TAP_RAW || sel_e == TAP_MIX) |=> vld_o);
  // R4: decimated taps follow their decimator's valid
  p_dec1_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_e == TAP_DEC1 && !dec1_vld_i) |=> !vld_o);
  p_dec2_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_e == TAP_DEC2 && !dec2_vld_i) |=> !vld_o);
endmodule

// File: rtl/iqf_dpram.sv
module iqf_dpram #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/iqf_wr_ctl.sv
module iqf_wr_ctl #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          vld_i,
  input  logic [DW-1:0] word_i,
  input  logic [AW:0]   rd_gray_s,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW:0]   wr_gray_o,
  output logic          ovf_o,
  output logic          ack_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_bin, wr_bin_nx;
  logic          full;

  assign full      = (wr_gray_o == {~rd_gray_s[AW:AW-1], rd_gray_s[AW-2:0]});
  assign we_o      = vld_i && !full && !hold;
  assign waddr_o   = wr_bin[AW-1:0];
  assign wdata_o   = word_i;
  assign wr_bin_nx = wr_bin + PW'(1);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      wr_bin    <= '0;
      wr_gray_o <= '0;
      ovf_o     <= 1'b0;
    end else begin
      if (we_o) begin
        wr_bin    <= wr_bin_nx;
        wr_gray_o <= wr_bin_nx ^ (wr_bin_nx >> 1);
      end
      if (vld_i && full) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ack_o <= 1'b0;
    else     ack_o <= hold;
  end

  // R8: a write offered while full does not advance the pointer
  p_drop_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    (vld_i && full && !hold) |=> $stable(wr_bin));
  // R9: overflow record survives until a flush
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !hold) |=> ovf_o);
  // R10: a flush held in this domain clears the overflow record
  p_flush_clears_ovf_r10: assert property (@(posedge clk) disable iff (rst)
    hold |=> !ovf_o);
endmodule

// File: rtl/iqf_rd_ctl.sv
module iqf_rd_ctl #(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int THRESH = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          rd_en,
  input  logic [AW:0]   wr_gray_s,
  input  logic [DW-1:0] q_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rd_gray_o,
  output logic [DW/2-1:0] rd_data_o,
  output logic          empty_o,
  output logic          thresh_o
);
  localparam int PW = AW + 1;
  localparam int HW = DW / 2;
  localparam logic [PW-1:0] TH = PW'(THRESH);

  logic [PW-1:0] rd_bin, rd_bin_nx, wr_bin_s, avail;
  logic          phase, half_q, thresh_q;

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  assign wr_bin_s  = gray_to_bin(wr_gray_s);
  assign avail     = wr_bin_s - rd_bin;
  assign empty_o   = busy || (rd_gray_o == wr_gray_s);
  assign re_o      = rd_en && !empty_o;
  assign raddr_o   = rd_bin[AW-1:0];
  assign rd_bin_nx = rd_bin + PW'(1);
  assign rd_data_o = half_q ? q_i[HW-1:0] : q_i[DW-1:HW];
  assign thresh_o  = thresh_q && !busy;

  always_ff @(posedge clk) begin
    if (rst || busy) begin
      rd_bin    <= '0;
      rd_gray_o <= '0;
      phase     <= 1'b0;
      thresh_q  <= 1'b0;
    end else begin
      if (re_o) begin
        phase <= ~phase;
        if (phase) begin
          rd_bin    <= rd_bin_nx;
          rd_gray_o <= rd_bin_nx ^ (rd_bin_nx >> 1);
        end
      end
      thresh_q <= (avail >= TH);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       half_q <= 1'b0;
    else if (re_o) half_q <= phase;
  end

  // R6: a read while empty consumes nothing
  p_empty_read_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty_o && !busy) |=> $stable(rd_bin));
  // R5: the I-half read never consumes the sample
  p_i_half_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (re_o && !phase) |=> $stable(rd_bin));
  // R7: a raised level flag implies data is available (THRESH >= 2)
  p_thresh_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    thresh_o |-> !empty_o);
endmodule

// File: rtl/iqf_flush_ctl.sv
module iqf_flush_ctl (
  input  logic clk,
  input  logic rst,
  input  logic flush_i,
  input  logic ack_s,
  output logic req_o,
  output logic busy_o
);
  typedef enum logic [1:0] {FL_IDLE, FL_REQ, FL_DROP} fl_state_e;
  fl_state_e state;

  always_ff @(posedge clk) begin
    if (rst) state <= FL_IDLE;
    else begin
      unique case (state)
        FL_IDLE: if (flush_i) state <= FL_REQ;
        FL_REQ:  if (ack_s)   state <= FL_DROP;
        FL_DROP: if (!ack_s)  state <= FL_IDLE;
        default:              state <= FL_IDLE;
      endcase
    end
  end

  assign req_o  = (state == FL_REQ);
  assign busy_o = (state != FL_IDLE);

  // R10: a flush request makes the read side busy (and thus empty) at once
  p_flush_starts_r10: assert property (@(posedge clk) disable iff (rst)
    (flush_i && state == FL_IDLE) |=> busy_o);
endmodule

// File: rtl/iqf_sample_fifo.sv
module iqf_sample_fifo #(
  parameter int SW     = iqf_pkg::SMP_W,
  parameter int AW     = 12,
  parameter int THRESH = 2048
) (
  input  logic            smp_clk,
  input  logic            smp_rst,
  input  logic [1:0]      tap_sel,
  input  logic [2*SW-1:0] tap_raw,
  input  logic [2*SW-1:0] tap_mix,
  input  logic [2*SW-1:0] tap_dec1,
  input  logic            dec1_vld,
  input  logic [2*SW-1:0] tap_dec2,
  input  logic            dec2_vld,
  output logic            ovf_flag,
  input  logic            ctl_clk,
  input  logic            ctl_rst,
  input  logic            flush,
  input  logic            rd_en,
  output logic [SW-1:0]   rd_data,
  output logic            empty,
  output logic            thresh_flag
);
  localparam int DW = 2 * SW;
  localparam int PW = AW + 1;

  logic [DW-1:0] mux_word, wdata, rdata_q;
  logic          mux_vld, we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  logic          fl_req, fl_hold, fl_ack, fl_ack_s, fl_busy;

  iqf_tap_mux #(.DW(DW)) u_mux (
    .clk(smp_clk), .rst(smp_rst), .sel_i(tap_sel),
    .raw_i(tap_raw), .mix_i(tap_mix),
    .dec1_i(tap_dec1), .dec1_vld_i(dec1_vld),
    .dec2_i(tap_dec2), .dec2_vld_i(dec2_vld),
    .word_o(mux_word), .vld_o(mux_vld)
  );

  iqf_wr_ctl #(.AW(AW), .DW(DW)) u_wr (
    .clk(smp_clk), .rst(smp_rst), .hold(fl_hold),
    .vld_i(mux_vld), .word_i(mux_word), .rd_gray_s(rd_gray_s),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .wr_gray_o(wr_gray), .ovf_o(ovf_flag), .ack_o(fl_ack)
  );

  iqf_dpram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(smp_clk), .we(we), .waddr(waddr), .wdata(wdata),
    .rclk(ctl_clk), .rrst(ctl_rst), .re(re), .raddr(raddr), .rdata(rdata_q)
  );

  iqf_rd_ctl #(.AW(AW), .DW(DW), .THRESH(THRESH)) u_rd (
    .clk(ctl_clk), .rst(ctl_rst), .busy(fl_busy), .rd_en(rd_en),
    .wr_gray_s(wr_gray_s), .q_i(rdata_q),
    .re_o(re), .raddr_o(raddr), .rd_gray_o(rd_gray),
    .rd_data_o(rd_data), .empty_o(empty), .thresh_o(thresh_flag)
  );

  iqf_flush_ctl u_flush (
    .clk(ctl_clk), .rst(ctl_rst), .flush_i(flush), .ack_s(fl_ack_s),
    .req_o(fl_req), .busy_o(fl_busy)
  );

  iqf_sync #(.W(PW)) u_sync_wptr (
    .clk(ctl_clk), .rst(ctl_rst), .d(wr_gray), .q(wr_gray_s));
  iqf_sync #(.W(PW)) u_sync_rptr (
    .clk(smp_clk), .rst(smp_rst), .d(rd_gray), .q(rd_gray_s));
  iqf_sync #(.W(1)) u_sync_req (
    .clk(smp_clk), .rst(smp_rst), .d(fl_req), .q(fl_hold));
  iqf_sync #(.W(1)) u_sync_ack (
    .clk(ctl_clk), .rst(ctl_rst), .d(fl_ack), .q(fl_ack_s));

  // R11: outputs at their idle values while in reset
  p_reset_state_r11: assert property (@(posedge ctl_clk)
    ctl_rst |=> (empty && !thresh_flag));
endmodule

// File: tb/iqf_sample_fifo_bench.sv
module iqf_sample_fifo_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SW     = 16;
  localparam int AW     = 12;
  localparam int DEPTH  = 1 << AW;
  localparam int THRESH = 2048;

  logic smp_clk = 1'b0, ctl_clk = 1'b0;
  always #3.5 smp_clk = ~smp_clk;
  always #2.5 ctl_clk = ~ctl_clk;

  logic smp_rst, ctl_rst, flush, rd_en, dec1_vld, dec2_vld;
  logic [1:0] tap_sel;
  logic [31:0] tap_raw, tap_mix, tap_dec1, tap_dec2;
  logic [15:0] rd_data;
  logic ovf_flag, empty, thresh_flag;

  iqf_sample_fifo #(.SW(SW), .AW(AW), .THRESH(THRESH)) u_iqf_sample_fifo (
    .smp_clk(smp_clk), .smp_rst(smp_rst), .tap_sel(tap_sel),
    .tap_raw(tap_raw), .tap_mix(tap_mix), .tap_dec1(tap_dec1), .dec1_vld(dec1_vld),
    .tap_dec2(tap_dec2), .dec2_vld(dec2_vld), .ovf_flag(ovf_flag),
    .ctl_clk(ctl_clk), .ctl_rst(ctl_rst), .flush(flush), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .thresh_flag(thresh_flag)
  );

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  logic exp_ovf = 1'b0;
  int seq_n = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected word selection per R2/R3/R4; capacity per R8; overflow per R9.
  function automatic logic tap_writes(logic [1:0] s, logic v1, logic v2);
    return (s == 2'd0) || (s == 2'd1) || (s == 2'd2 && v1) || (s == 2'd3 && v2);
  endfunction

  function automatic logic [31:0] tap_word(logic [1:0] s, logic [31:0] r, logic [31:0] m,
                                           logic [31:0] a, logic [31:0] b);
    case (s)
      2'd0: return r;
      2'd1: return m;
      2'd2: return a;
      default: return b;
    endcase
  endfunction

  task automatic drive(input logic [1:0] s, input logic [31:0] r, input logic [31:0] m,
                       input logic [31:0] a, input logic v1, input logic [31:0] b, input logic v2);
    @(negedge smp_clk);
    tap_sel = s; tap_raw = r; tap_mix = m; tap_dec1 = a; dec1_vld = v1; tap_dec2 = b; dec2_vld = v2;
    if (tap_writes(s, v1, v2)) begin
      if (exp_q.size() < DEPTH) exp_q.push_back(tap_word(s, r, m, a, b));
      else exp_ovf = 1'b1;
    end
  endtask

  task automatic idle();
    drive(2'd2, 32'h0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic seq_fill(input int n);
    for (int k = 0; k < n; k++) begin
      drive(2'd0, {seq_n[15:0], ~seq_n[15:0]}, 32'hDEAD0000, 32'h0, 1'b0, 32'h0, 1'b0);
      seq_n++;
    end
    idle();
  endtask

  task automatic ctl_wait(input int n);
    repeat (n) @(negedge ctl_clk);
  endtask

  task automatic rd_half(output logic [15:0] v);
    @(negedge ctl_clk) rd_en = 1'b1;
    @(negedge ctl_clk) rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic pop_check(input string tag);
    logic [31:0] w;
    logic [15:0] v;
    w = exp_q.pop_front();
    rd_half(v);
    chk({tag, " I half"}, 32'(v), 32'(w[31:16]));
    rd_half(v);
    chk({tag, " Q half"}, 32'(v), 32'(w[15:0]));
  endtask

  task automatic do_flush();
    @(negedge ctl_clk) flush = 1'b1;
    @(negedge ctl_clk) flush = 1'b0;
    ctl_wait(40);
    exp_q.delete();
    exp_ovf = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge ctl_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, held;
    int unsigned r;
    r = $urandom(32'h5EED1234);
    smp_rst = 1'b1; ctl_rst = 1'b1; flush = 1'b0; rd_en = 1'b0;
    tap_sel = 2'd2; tap_raw = '0; tap_mix = '0; tap_dec1 = '0; tap_dec2 = '0;
    dec1_vld = 1'b0; dec2_vld = 1'b0;
    ctl_wait(10);
    @(negedge smp_clk) smp_rst = 1'b0;
    @(negedge ctl_clk) ctl_rst = 1'b0;
    ctl_wait(4);
    chk("R11 empty after reset", 32'(empty), 32'd1);
    chk("R11 thresh after reset", 32'(thresh_flag), 32'd0);
    chk("R11 ovf after reset", 32'(ovf_flag), 32'd0);
    chk("R11 rd_data after reset", 32'(rd_data), 32'd0);

    // R1/R2/R3/R4: random tap choice, data and decimator valids
    for (int blk = 0; blk < 4; blk++) begin
      for (int k = 0; k < 50; k++)
        drive(2'($urandom()), $urandom(), $urandom(), $urandom(), 1'($urandom()),
              $urandom(), 1'($urandom()));
      idle();
      ctl_wait(20);
      while (exp_q.size() > 0) pop_check("R1 R2 R3 R4 R5 random stream");
      ctl_wait(4);
      chk("R5 empty after drain", 32'(empty), 32'd1);
    end

    // R4 directed: decimated taps with valid low store nothing
    drive(2'd3, 32'h0, 32'h0, 32'h11112222, 1'b1, 32'h33334444, 1'b0);
    drive(2'd2, 32'h0, 32'h0, 32'h55556666, 1'b0, 32'h77778888, 1'b1);
    drive(2'd3, 32'h0, 32'h0, 32'h0, 1'b0, 32'h9999AAAA, 1'b1);
    idle();
    ctl_wait(20);
    chk("R4 only one decimated word stored", 32'(exp_q.size()), 32'd1);
    pop_check("R4 decimator 2 word");
    ctl_wait(4);
    chk("R4 nothing else stored", 32'(empty), 32'd1);

    // R6: reads while empty are ignored
    held = rd_data;
    for (int k = 0; k < 3; k++) begin
      rd_half(v);
      chk("R6 rd_data holds on empty read", 32'(v), 32'(held));
    end
    drive(2'd1, 32'h0, 32'hBEEF1234, 32'h0, 1'b0, 32'h0, 1'b0);
    idle();
    ctl_wait(20);
    pop_check("R6 no sample consumed by empty reads");

    // R7: level flag around the threshold
    seq_fill(THRESH - 1);
    ctl_wait(12);
    chk("R7 thresh low at THRESH-1", 32'(thresh_flag), 32'd0);
    seq_fill(1);
    ctl_wait(12);
    chk("R7 thresh high at THRESH", 32'(thresh_flag), 32'd1);
    pop_check("R7 read one sample");
    ctl_wait(12);
    chk("R7 thresh low after one read", 32'(thresh_flag), 32'd0);

    // R8/R9: overfill, drop the newest, keep the stored order
    seq_fill(DEPTH - exp_q.size() + 5);
    ctl_wait(20);
    chk("R9 ovf set on dropped writes", 32'(ovf_flag), 32'(exp_ovf));
    chk("R8 model holds full depth", 32'(exp_q.size()), 32'(DEPTH));
    chk("R7 thresh high when full", 32'(thresh_flag), 32'd1);
    while (exp_q.size() > 0) pop_check("R8 full drain order");
    ctl_wait(20);
    chk("R8 empty after full drain", 32'(empty), 32'd1);
    chk("R9 ovf still set after drain", 32'(ovf_flag), 32'd1);

    // R10: flush clears overflow and stored data
    do_flush();
    chk("R10 ovf cleared by flush", 32'(ovf_flag), 32'd0);
    chk("R10 empty after flush", 32'(empty), 32'd1);
    seq_fill(10);
    ctl_wait(20);
    chk("R10 data present before flush", 32'(empty), 32'd0);
    held = rd_data;
    do_flush();
    chk("R10 empty after flush with data", 32'(empty), 32'd1);
    chk("R10 thresh low after flush", 32'(thresh_flag), 32'd0);
    chk("R10 rd_data kept over flush", 32'(rd_data), 32'(held));
    rd_half(v);
    chk("R10 read after flush ignored", 32'(v), 32'(held));
    seq_fill(3);
    ctl_wait(20);
    while (exp_q.size() > 0) pop_check("R10 new data after flush");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule